// File: doc/BRIEF.md
# Alignment Fault Status Encoder

This block runs when a load or store has been found to be misaligned. On that fault strobe it takes the 32-bit instruction word that faulted and the effective address it used. It sorts the instruction into one of three classes: displacement-addressed, register-indexed, or not recognised. From that class it builds a 32-bit fault status word that tells a handler what the access was. In the same clock edge it captures the effective address into a fault address register.

Both registers load together on one edge and then hold until the next fault. In the cycle after each fault the block also sends a one-cycle request to the exception entry sequencer. The request carries no extra status. A sticky diagnostic flag records that a fault came from an instruction the encoder did not recognise. Software clears the flag with a write strobe.

Top module: `aflt_encoder`

Bit positions below use vector numbering, where bit 0 is the least significant. The instruction's primary opcode is `insn[31:26]`, its extended opcode is `insn[10:1]` and its record bit is `insn[0]`.

## Requirements
- R1: An instruction is displacement-addressed when its primary opcode is one of 32, 33, 36, 37 or 40 to 55. For such an instruction the status word takes `status[14] = insn[26]` and `status[13:10] = insn[30:27]`.
- R2: An instruction is register-indexed when all three of these hold: its primary opcode is 31, its record bit is 0, and its extended opcode is in the supported set {20, 23, 55, 150, 151, 183, 279, 310, 311, 341, 343, 373, 375, 407, 438, 439, 533, 534, 535, 567, 597, 599, 631, 661, 662, 663, 695, 725, 727, 759, 790, 918}. For such an instruction the status word takes `status[16:15] = insn[2:1]`, `status[14] = insn[6]` and `status[13:10] = insn[10:7]`.
- R3: Primary opcode 31 with extended opcode 1014 (cache-block zero) is treated as register-indexed only when the record bit is 0 and `insn[25:21]` is 0. Any other value makes it unrecognised.
- R4: For an unrecognised instruction, `status[16:10]` is 0. `status[31:17]` is 0 for every class.
- R5: `status[9:5]` always takes `insn[25:21]`, the data register field.
- R6: `status[4:0]` takes `insn[20:16]`, the base register field. It is 0 for three instructions: primary opcode 46, and opcode 31 with extended opcode 533 or 597.
- R7: The fault address output takes the effective address presented with the fault strobe.
- R8: The status and address outputs change only on the edge where the fault strobe is high, and show the new values from the next cycle. When the strobe is low they hold.
- R9: The exception request is high for exactly the one cycle after each cycle in which the fault strobe is high, and low otherwise.
- R10: The diagnostic flag sets when an unrecognised instruction faults. It stays set until a clear strobe arrives without such a fault in the same cycle. A new unrecognised fault wins over a clear in the same cycle.
- R11: While reset is asserted, the status, address, request and flag outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 1 | Alignment fault strobe |
| insn_i | input | 32 | Faulting instruction word |
| ea_i | input | 32 | Effective address of the faulting access |
| diag_clr_i | input | 1 | Write strobe that clears the diagnostic flag |
| status_o | output | 32 | Fault status word |
| addr_o | output | 32 | Fault address |
| exc_req_o | output | 1 | Request to the exception entry sequencer |
| unexp_o | output | 1 | Sticky flag for an unrecognised faulting instruction |

## Verification
Some rules are checked by assertions on every cycle. These cover the address capture, the holding of both registers between faults, the timing of the request pulse, the copying of the data register field, the zero form bits for an unrecognised instruction, and the sticky flag with its clear priority. Other behaviour can only be shown by the bench's instruction vectors. These are the bit placement for each form, membership of the opcode sets, the exact conditions for cache-block zero, the record bit, and the three instructions that drop the base register field.

// File: rtl/aflt_pkg.sv
package aflt_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned STAT_W = 32;
  localparam int unsigned OP_W   = 6;
  localparam int unsigned XO_W   = 10;
  localparam int unsigned REG_W  = 5;

  localparam logic [OP_W-1:0] OP_XFORM   = 6'd31;
  localparam logic [OP_W-1:0] OP_LDMULTI = 6'd46;
  localparam logic [XO_W-1:0] XO_BLKZERO = 10'd1014;
  localparam logic [XO_W-1:0] XO_LSTR_X  = 10'd533;
  localparam logic [XO_W-1:0] XO_LSTR_I  = 10'd597;

  typedef enum logic [1:0] {
    FORM_NONE = 2'd0,
    FORM_IMM  = 2'd1,
    FORM_IDX  = 2'd2
  } aflt_form_e;

  function automatic logic is_imm_op(input logic [OP_W-1:0] op);
    return (op == 6'd32) || (op == 6'd33) || (op == 6'd36) || (op == 6'd37) ||
           ((op >= 6'd40) && (op <= 6'd55));
  endfunction

  function automatic logic is_idx_xo(input logic [XO_W-1:0] xo);
    logic hit;
    case (xo)
      10'd20, 10'd23, 10'd55, 10'd150, 10'd151, 10'd183, 10'd279, 10'd310,
      10'd311, 10'd341, 10'd343, 10'd373, 10'd375, 10'd407, 10'd438, 10'd439,
      10'd533, 10'd534, 10'd535, 10'd567, 10'd597, 10'd599, 10'd631, 10'd661,
      10'd662, 10'd663, 10'd695, 10'd725, 10'd727, 10'd759, 10'd790, 10'd918:
        hit = 1'b1;
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/aflt_classify.sv
module aflt_classify
  import aflt_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [REG_W-1:0] rt_i,
  input  logic [XO_W:0]    xo_rc_i,
  output aflt_form_e       form_o,
  output logic             keep_ra_o
);
  logic [XO_W-1:0] xo;
  logic            rc;
  logic            is_x;
  logic            blkzero;

  assign xo      = xo_rc_i[XO_W:1];
  assign rc      = xo_rc_i[0];
  assign is_x    = (op_i == OP_XFORM) && !rc;
  assign blkzero = is_x && (xo == XO_BLKZERO) && (rt_i == '0);

  always_comb begin
    form_o = FORM_NONE;
    if (is_imm_op(op_i)) begin
      form_o = FORM_IMM;
    end else if ((is_x && is_idx_xo(xo)) || blkzero) begin
      form_o = FORM_IDX;
    end
  end

  always_comb begin
    keep_ra_o = 1'b1;
    if ((form_o == FORM_IMM) && (op_i == OP_LDMULTI)) begin
      keep_ra_o = 1'b0;
    end else if ((form_o == FORM_IDX) && ((xo == XO_LSTR_X) || (xo == XO_LSTR_I))) begin
      keep_ra_o = 1'b0;
    end
  end
endmodule

// File: rtl/aflt_status_build.sv
module aflt_status_build
  import aflt_pkg::*;
(
  input  aflt_form_e        form_i,
  input  logic              keep_ra_i,
  input  logic [14:0]       hi_i,
  input  logic [XO_W-1:0]   lo_i,
  output logic [STAT_W-1:0] status_o
);
  always_comb begin
    status_o = '0;
    case (form_i)
      FORM_IMM: begin
        status_o[14]    = hi_i[10];
        status_o[13:10] = hi_i[14:11];
      end
      FORM_IDX: begin
        status_o[16:15] = lo_i[1:0];
        status_o[14]    = lo_i[5];
        status_o[13:10] = lo_i[9:6];
      end
      default: status_o[16:10] = '0;
    endcase
    status_o[9:5] = hi_i[9:5];
    status_o[4:0] = keep_ra_i ? hi_i[4:0] : 5'd0;
  end
endmodule

// File: rtl/aflt_encoder.sv
module aflt_encoder
  import aflt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic              diag_clr_i,
  output logic [STAT_W-1:0] status_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              exc_req_o,
  output logic              unexp_o
);
  aflt_form_e        form;
  logic              keep_ra;
  logic [STAT_W-1:0] status_nx;
  logic [STAT_W-1:0] status_q;
  logic [ADDR_W-1:0] addr_q;
  logic              req_q;
  logic              unexp_q;
  logic              unexp_nx;
  logic              cap_en;

  aflt_classify u_classify (
    .op_i      (insn_i[31:26]),
    .rt_i      (insn_i[25:21]),
    .xo_rc_i   (insn_i[10:0]),
    .form_o    (form),
    .keep_ra_o (keep_ra)
  );

  aflt_status_build u_build (
    .form_i    (form),
    .keep_ra_i (keep_ra),
    .hi_i      (insn_i[30:16]),
    .lo_i      (insn_i[10:1]),
    .status_o  (status_nx)
  );

  assign cap_en = fault_i;

  always_comb begin
    unexp_nx = unexp_q;
    if (diag_clr_i) unexp_nx = 1'b0;
    if (fault_i && (form == FORM_NONE)) unexp_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      addr_q   <= '0;
    end else if (cap_en) begin
      status_q <= status_nx;
      addr_q   <= ea_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      unexp_q <= 1'b0;
    end else begin
      req_q   <= fault_i;
      unexp_q <= unexp_nx;
    end
  end

  assign status_o  = status_q;
  assign addr_o    = addr_q;
  assign exc_req_o = req_q;
  assign unexp_o   = unexp_q;

  p_addr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (addr_o == $past(ea_i)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_i |=> ($stable(status_o) && $stable(addr_o)));

  p_req_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> exc_req_o);

  p_req_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_i |=> !exc_req_o);

  p_rt_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (status_o[9:5] == $past(insn_i[25:21])));

  p_unexp_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_i && (form == FORM_NONE)) |=> (status_o[16:10] == '0) && unexp_o);

  p_high_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[31:17] == '0);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (unexp_o && !diag_clr_i) |=> unexp_o);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_clr_i && !fault_i) |=> !unexp_o);
endmodule

// File: tb/aflt_encoder_bench.sv
module aflt_encoder_bench;
  typedef struct packed {
    logic [31:0] insn;
    logic [31:0] exp_stat;
    logic        exp_unexp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h80A90010, 32'h000000A9, 1'b0},  // R1 displacement, low opcode
    '{32'h97E10000, 32'h00004BE1, 1'b0},  // R1 opcode 37
    '{32'hCC43FFF8, 32'h00006443, 1'b0},  // R1 opcode 51
    '{32'hBA840000, 32'h00001E80, 1'b0},  // R6 opcode 46 drops base
    '{32'h7CE8482E, 32'h000180E8, 1'b0},  // R2 xo 23
    '{32'h7C2235EE, 32'h0001EC22, 1'b0},  // R2 xo 759
    '{32'h7D4B642A, 32'h0000A140, 1'b0},  // R6 xo 533 drops base
    '{32'h7C642CAA, 32'h0000A460, 1'b0},  // R6 xo 597 drops base
    '{32'h7C0537EC, 32'h00017C05, 1'b0},  // R3 block zero
    '{32'h7C2537EC, 32'h00000025, 1'b1},  // R3 block zero, rt nonzero
    '{32'h38640001, 32'h00000064, 1'b1},  // R4 unlisted opcode
    '{32'h7CE8482F, 32'h000000E8, 1'b1},  // R2 record bit set
    '{32'h88430000, 32'h00000043, 1'b1},  // R4 opcode 34 not listed
    '{32'h7C85312C, 32'h00010885, 1'b0}   // R2 xo 150
  };

  logic        clk;
  logic        rst_n;
  logic        fault_i;
  logic [31:0] insn_i;
  logic [31:0] ea_i;
  logic        diag_clr_i;
  logic [31:0] status_o;
  logic [31:0] addr_o;
  logic        exc_req_o;
  logic        unexp_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  aflt_encoder u_aflt_encoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_i    (fault_i),
    .insn_i     (insn_i),
    .ea_i       (ea_i),
    .diag_clr_i (diag_clr_i),
    .status_o   (status_o),
    .addr_o     (addr_o),
    .exc_req_o  (exc_req_o),
    .unexp_o    (unexp_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fault(input logic [31:0] insn, input logic [31:0] ea, input logic clr);
    @(negedge clk);
    fault_i    = 1'b1;
    insn_i     = insn;
    ea_i       = ea;
    diag_clr_i = clr;
    @(negedge clk);
    fault_i    = 1'b0;
    diag_clr_i = 1'b0;
    insn_i     = ~insn;
    ea_i       = ~ea;
  endtask

  task automatic clear();
    @(negedge clk);
    diag_clr_i = 1'b1;
    @(negedge clk);
    diag_clr_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; fault_i = 1'b0; insn_i = '0; ea_i = '0; diag_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 status", status_o, 32'h0);
    chk("R11 addr", addr_o, 32'h0);
    chk("R11 req", {31'b0, exc_req_o}, 32'h0);
    chk("R11 flag", {31'b0, unexp_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] ea;
      ea = 32'h5A5A0000 ^ VECS[i].insn ^ 32'(i);
      fault(VECS[i].insn, ea, 1'b0);
      chk("R1/R2/R3/R4/R5/R6 status", status_o, VECS[i].exp_stat);
      chk("R7 addr", addr_o, ea);
      chk("R9 req high", {31'b0, exc_req_o}, 32'h1);
      chk("R10 flag", {31'b0, unexp_o}, {31'b0, VECS[i].exp_unexp});
      @(negedge clk);
      chk("R9 req low", {31'b0, exc_req_o}, 32'h0);
      chk("R8 hold", status_o, VECS[i].exp_stat);
      clear();
    end

    // R8: inputs change with no strobe, outputs hold
    fault(32'h80A90010, 32'h00001234, 1'b0);
    @(negedge clk); insn_i = 32'h7C0537EC; ea_i = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    chk("R8 status hold", status_o, 32'h000000A9);
    chk("R8 addr hold", addr_o, 32'h00001234);

    // R10: flag sticky through recognised faults, cleared by strobe
    fault(32'h38640001, 32'h100, 1'b0);
    fault(32'h7CE8482E, 32'h104, 1'b0);
    fault(32'h80A90010, 32'h108, 1'b0);
    chk("R10 sticky", {31'b0, unexp_o}, 32'h1);
    clear();
    chk("R10 cleared", {31'b0, unexp_o}, 32'h0);

    // R10: set wins over clear in the same cycle
    fault(32'h88430000, 32'h10C, 1'b1);
    chk("R10 set beats clear", {31'b0, unexp_o}, 32'h1);
    // R10: clear with a recognised fault clears
    fault(32'h80A90010, 32'h110, 1'b1);
    chk("R10 clear with recognised", {31'b0, unexp_o}, 32'h0);

    // R9: back-to-back strobes keep the request high
    @(negedge clk);
    fault_i = 1'b1; insn_i = 32'h97E10000; ea_i = 32'h200;
    @(negedge clk);
    chk("R9 first", {31'b0, exc_req_o}, 32'h1);
    insn_i = 32'hCC43FFF8; ea_i = 32'h204;
    @(negedge clk);
    fault_i = 1'b0;
    chk("R9 second", {31'b0, exc_req_o}, 32'h1);
    chk("R1 back-to-back status", status_o, 32'h00006443);
    chk("R7 back-to-back addr", addr_o, 32'h204);
    @(negedge clk);
    chk("R9 drop", {31'b0, exc_req_o}, 32'h0);

    // R11: reset in mid-run clears everything
    fault(32'h38640001, 32'h300, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R11 status again", status_o, 32'h0);
    chk("R11 flag again", {31'b0, unexp_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule